// File: doc/BRIEF.md
# Keyboard matrix scanner with freeze

The block walks a 6-bit scan count across an 8 by 8 switch matrix. The upper three bits of the count choose which drive line is pulled low. The lower three bits choose which sense line is examined. When the examined sense line reads low, the selected switch is closed, and the count stops on that position. The frozen count is the key code, equal to row times eight plus column. The count stays frozen for as long as the switch stays closed. When the switch opens, scanning resumes from the next position.

Detection starts a debounce timer, measured in scan clock cycles. If the switch is still closed when the timer expires, the frozen count is copied into the key code output and a validate strobe of fixed length is raised. A release before expiry produces no strobe.

Keys on one designated row are mode keys. The first confirmed mode key is loaded into a mode latch. Every later mode key is refused until a separate clear input empties the latch. A mode-active flag shows that the accepted mode key is still held down.

Top module: `kbs_matrix_scanner`

## Requirements
- R1: Exactly one drive line is low at any time: line number count[5:3]. In reset the count is 0, so the drive output reads 8'hFE, and the key code, strobe, mode code, lock and mode-active outputs are all 0.
- R2: The sense line numbered count[2:0] is examined, and a low level on it means a closed switch. While it is low, the count holds its value, so the drive line stays on the key's row for the whole time the key is closed.
- R3: While no closed switch is examined, the count rises by one each clock, carrying from the column bits into the row bits and wrapping from 63 to 0. After a release the count continues from the frozen value plus one, so the next row's drive line goes low 8 - column cycles after the release.
- R4: If the key stays closed for DBNC clock edges after the first cycle it is examined, the strobe rises on edge DBNC and the key code output takes row*8+column. If the key is held for fewer edges, no strobe appears and the key code output is unchanged.
- R5: The strobe stays high for exactly STRB cycles, and there is only one strobe per press, however long the key is held.
- R6: A confirmed key on row MODE_ROW (default 7) is accepted when the lock is clear. The mode code output takes the key code and the lock output goes high on the same edge as the strobe.
- R7: While the lock is high, a confirmed mode key still gives a strobe and updates the key code. The mode code output does not change.
- R8: The mode-active output goes high with the strobe of an accepted mode key. It falls on the edge after that key is released. A refused mode key never sets it.
- R9: A high level on the clear input empties the latch on the next edge: mode code 0, lock 0, mode-active 0. A later mode key is then accepted again.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Scan clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sense_n_i | input | 8 | Sense lines, low when the addressed switch is closed |
| mode_clr_i | input | 1 | Reset key indication, clears the mode latch |
| drive_n_o | output | 8 | Drive lines, one active low |
| key_code_o | output | 6 | Last validated key code, row*8+column |
| key_valid_o | output | 1 | Validate strobe, STRB cycles long |
| mode_code_o | output | 6 | Latched mode key code |
| mode_lock_o | output | 1 | Mode latch occupied |
| mode_active_o | output | 1 | Accepted mode key still held |

## Verification
All timing is counted in samples taken on the falling clock edge. Sample 0 is the first sample on which the target key's drive line is low. The count reaches the key's column at sample c. The strobe, the key code and the mode outputs are due at sample c+DBNC. For a release after sample c+h, mode-active must be low at sample c+h+1 and the next row must first appear at sample h+8. Each press is checked against these fixed sample indices, and the bench records the first strobe sample and the number of strobe samples over a window long enough to contain the whole strobe.

// File: rtl/kbs_pkg.sv
package kbs_pkg;
  localparam int unsigned KBS_ROW_W    = 3;
  localparam int unsigned KBS_COL_W    = 3;
  localparam int unsigned KBS_DBNC     = 20;
  localparam int unsigned KBS_STRB     = 4;
  localparam int unsigned KBS_MODE_ROW = 7;

  typedef struct packed {
    logic accept;
    logic refuse;
  } kbs_mode_evt_t;
endpackage

// File: rtl/kbs_scan_ctr.sv
module kbs_scan_ctr #(
  parameter int unsigned ROW_W = 3,
  parameter int unsigned COL_W = 3,
  localparam int unsigned CODE_W = ROW_W + COL_W,
  localparam int unsigned ROWS   = 1 << ROW_W,
  localparam int unsigned COLS   = 1 << COL_W
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic [COLS-1:0]   sense_n_i,
  output logic [CODE_W-1:0] cnt_o,
  output logic [ROWS-1:0]   drive_n_o,
  output logic              hit_o
);
  logic [CODE_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  assign hit_o  = ~sense_n_i[cnt_q[COL_W-1:0]];
  assign cnt_en = ~hit_o;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < ROWS; g++) begin : g_drive
    assign drive_n_o[g] = (cnt_q[CODE_W-1:COL_W] != ROW_W'(g));
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/kbs_debounce.sv
module kbs_debounce #(
  parameter int unsigned CODE_W = 6,
  parameter int unsigned DBNC   = 20,
  parameter int unsigned STRB   = 4,
  localparam int unsigned DW = $clog2(DBNC + 1),
  localparam int unsigned SW = $clog2(STRB + 1)
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              hit_i,
  input  logic [CODE_W-1:0] cnt_i,
  output logic              confirm_o,
  output logic [CODE_W-1:0] key_code_o,
  output logic              key_valid_o
);
  logic [DW-1:0]     deb_q, deb_d;
  logic              done_q, done_d;
  logic [SW-1:0]     str_q, str_d;
  logic [CODE_W-1:0] code_q;
  logic              expire;

  assign expire    = (deb_q == DW'(DBNC - 1));
  assign confirm_o = hit_i & ~done_q & expire;

  always_comb begin
    deb_d  = deb_q;
    done_d = hit_i & (done_q | confirm_o);
    str_d  = str_q;
    if (!hit_i)                  deb_d = '0;
    else if (!done_q && !expire) deb_d = deb_q + 1'b1;
    if (confirm_o)               str_d = SW'(STRB);
    else if (str_q != '0)        str_d = str_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      deb_q  <= '0;
      done_q <= 1'b0;
      str_q  <= '0;
    end else begin
      deb_q  <= deb_d;
      done_q <= done_d;
      str_q  <= str_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)         code_q <= '0;
    else if (confirm_o) code_q <= cnt_i;
  end

  assign key_code_o  = code_q;
  assign key_valid_o = (str_q != '0);
endmodule

// File: rtl/kbs_mode.sv
module kbs_mode
  import kbs_pkg::*;
#(
  parameter int unsigned ROW_W    = 3,
  parameter int unsigned COL_W    = 3,
  parameter int unsigned MODE_ROW = 7,
  localparam int unsigned CODE_W = ROW_W + COL_W
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              confirm_i,
  input  logic              hit_i,
  input  logic [CODE_W-1:0] cnt_i,
  input  logic              clr_i,
  output logic [CODE_W-1:0] mode_code_o,
  output logic              mode_lock_o,
  output logic              mode_active_o
);
  kbs_mode_evt_t     evt;
  logic              is_mode;
  logic [CODE_W-1:0] code_q, code_d;
  logic              lock_q, lock_d, act_q, act_d;

  assign is_mode    = (cnt_i[CODE_W-1:COL_W] == ROW_W'(MODE_ROW));
  assign evt.accept = confirm_i & is_mode & ~lock_q;
  assign evt.refuse = confirm_i & is_mode & lock_q;

  always_comb begin
    code_d = code_q;
    lock_d = lock_q;
    act_d  = act_q & hit_i;
    if (clr_i) begin
      code_d = '0;
      lock_d = 1'b0;
      act_d  = 1'b0;
    end else if (evt.accept) begin
      code_d = cnt_i;
      lock_d = 1'b1;
      act_d  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      lock_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      lock_q <= lock_d;
      act_q  <= act_d;
    end
  end

  assign mode_code_o   = code_q;
  assign mode_lock_o   = lock_q;
  assign mode_active_o = act_q;
endmodule

// File: rtl/kbs_matrix_scanner.sv
module kbs_matrix_scanner
  import kbs_pkg::*;
#(
  parameter int unsigned ROW_W    = KBS_ROW_W,
  parameter int unsigned COL_W    = KBS_COL_W,
  parameter int unsigned DBNC     = KBS_DBNC,
  parameter int unsigned STRB     = KBS_STRB,
  parameter int unsigned MODE_ROW = KBS_MODE_ROW,
  localparam int unsigned CODE_W = ROW_W + COL_W,
  localparam int unsigned ROWS   = 1 << ROW_W,
  localparam int unsigned COLS   = 1 << COL_W
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic [COLS-1:0]   sense_n_i,
  input  logic              mode_clr_i,
  output logic [ROWS-1:0]   drive_n_o,
  output logic [CODE_W-1:0] key_code_o,
  output logic              key_valid_o,
  output logic [CODE_W-1:0] mode_code_o,
  output logic              mode_lock_o,
  output logic              mode_active_o
);
  logic [1:0]        rst_sync;
  logic              rst_q;
  logic [CODE_W-1:0] scan_cnt;
  logic              hit;
  logic              confirm;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync <= '0;
    else          rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  kbs_scan_ctr #(.ROW_W(ROW_W), .COL_W(COL_W)) scan_i (
    .clk_i     (clk_i),
    .rst_n     (rst_q),
    .sense_n_i (sense_n_i),
    .cnt_o     (scan_cnt),
    .drive_n_o (drive_n_o),
    .hit_o     (hit)
  );

  kbs_debounce #(.CODE_W(CODE_W), .DBNC(DBNC), .STRB(STRB)) deb_i (
    .clk_i       (clk_i),
    .rst_n       (rst_q),
    .hit_i       (hit),
    .cnt_i       (scan_cnt),
    .confirm_o   (confirm),
    .key_code_o  (key_code_o),
    .key_valid_o (key_valid_o)
  );

  kbs_mode #(.ROW_W(ROW_W), .COL_W(COL_W), .MODE_ROW(MODE_ROW)) mode_i (
    .clk_i         (clk_i),
    .rst_n         (rst_q),
    .confirm_i     (confirm),
    .hit_i         (hit),
    .cnt_i         (scan_cnt),
    .clr_i         (mode_clr_i),
    .mode_code_o   (mode_code_o),
    .mode_lock_o   (mode_lock_o),
    .mode_active_o (mode_active_o)
  );
endmodule

// File: rtl/kbs_matrix_scanner_chk.sv
module kbs_matrix_scanner_chk #(
  parameter int unsigned CODE_W = 6,
  parameter int unsigned ROWS   = 8,
  parameter int unsigned STRB   = 4
) (
  input logic              clk_i,
  input logic              rst_q,
  input logic [CODE_W-1:0] cnt,
  input logic              hit,
  input logic [ROWS-1:0]   drive_n_o,
  input logic              key_valid_o,
  input logic              mode_clr_i,
  input logic [CODE_W-1:0] mode_code_o,
  input logic              mode_lock_o,
  input logic              mode_active_o
);
  logic [15:0] run_q;

  always_ff @(posedge clk_i or negedge rst_q) begin
    if (!rst_q)           run_q <= '0;
    else if (key_valid_o) run_q <= run_q + 1'b1;
    else                  run_q <= '0;
  end

  AST_ONE_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_q) $countones(~drive_n_o) == 1); // R1
  AST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_q) hit |=> cnt == $past(cnt)); // R2
  AST_STEP: assert property (@(posedge clk_i) disable iff (!rst_q) !hit |=> cnt == CODE_W'($past(cnt) + 1'b1)); // R3
  AST_CONFIRM_HIT: assert property (@(posedge clk_i) disable iff (!rst_q) $rose(key_valid_o) |-> $past(hit)); // R4
  AST_STROBE_LEN: assert property (@(posedge clk_i) disable iff (!rst_q) run_q <= 16'(STRB)); // R5
  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_q) mode_lock_o && !mode_clr_i |=> mode_code_o == $past(mode_code_o)); // R7
  AST_ACTIVE_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_q) mode_active_o |-> mode_lock_o); // R8
  AST_CLR: assert property (@(posedge clk_i) disable iff (!rst_q) mode_clr_i |=> !mode_lock_o && !mode_active_o); // R9
endmodule

bind kbs_matrix_scanner kbs_matrix_scanner_chk #(
  .CODE_W (CODE_W),
  .ROWS   (ROWS),
  .STRB   (STRB)
) chk_i (
  .clk_i         (clk_i),
  .rst_q         (rst_q),
  .cnt           (scan_cnt),
  .hit           (hit),
  .drive_n_o     (drive_n_o),
  .key_valid_o   (key_valid_o),
  .mode_clr_i    (mode_clr_i),
  .mode_code_o   (mode_code_o),
  .mode_lock_o   (mode_lock_o),
  .mode_active_o (mode_active_o)
);

// File: tb/kbs_matrix_scanner_tb_top.sv
module kbs_matrix_scanner_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DBNC     = 20;
  localparam int STRB     = 4;
  localparam int MODE_ROW = 7;

  logic       clk_i = 1'b0;
  logic       rst_n_i;
  logic [7:0] sense_n_i;
  logic       mode_clr_i;
  logic [7:0] drive_n_o;
  logic [5:0] key_code_o;
  logic       key_valid_o;
  logic [5:0] mode_code_o;
  logic       mode_lock_o;
  logic       mode_active_o;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  key_on   = 1'b0;
  int  key_r    = 0;
  int  key_c    = 0;
  int  exp_code = 0;
  int  exp_mcode = 0;
  bit  exp_lock = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  kbs_matrix_scanner #(.DBNC(DBNC), .STRB(STRB), .MODE_ROW(MODE_ROW)) dut_i (
    .clk_i, .rst_n_i, .sense_n_i, .mode_clr_i, .drive_n_o,
    .key_code_o, .key_valid_o, .mode_code_o, .mode_lock_o, .mode_active_o
  );

  always_comb begin
    sense_n_i = 8'hFF;
    if (key_on && drive_n_o[key_r] == 1'b0) sense_n_i[key_c] = 1'b0;
  end

  function automatic bit is_accepted(int r, bit strobe, bit locked);
    return strobe && (r == MODE_ROW) && !locked;
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_row(int r, bit active);
    int n = 0;
    while ((drive_n_o[r] == 1'b0) != active && n < 200) begin
      @(negedge clk_i);
      n++;
    end
    chk(n < 200, "R3 scan reaches row", n, 0);
  endtask

  // Press key (r,c) and release it h edges after the count first reaches it.
  task automatic do_press(int r, int c, int h);
    int  rise_at = -1, hi_cnt = 0, next_at = -1, end_i;
    bit  froze_ok = 1'b1, act_h = 1'b0, act_r = 1'b1, exp_s, acc;
    int  nr = (r + 1) % 8;
    wait_row(r, 1'b0);
    key_r = r; key_c = c; key_on = 1'b1;
    wait_row(r, 1'b1);
    end_i = c + h + DBNC + STRB + 12;
    for (int i = 0; i <= end_i; i++) begin
      if (i > 0) @(negedge clk_i);
      if (key_valid_o) begin
        hi_cnt++;
        if (rise_at < 0) rise_at = i;
      end
      if (i >= c && i <= c + h && drive_n_o[r] !== 1'b0) froze_ok = 1'b0;
      if (i == c + h) begin
        act_h  = mode_active_o;
        key_on = 1'b0;
      end
      if (i == c + h + 1) act_r = mode_active_o;
      if (i > c + h && next_at < 0 && drive_n_o[nr] === 1'b0) next_at = i;
    end
    exp_s = (h >= DBNC);
    acc   = is_accepted(r, exp_s, exp_lock);
    if (exp_s) exp_code = r * 8 + c;
    if (acc) begin
      exp_mcode = r * 8 + c;
      exp_lock  = 1'b1;
    end
    chk(froze_ok, "R2 drive row held while key closed", froze_ok, 1);
    chk(rise_at == (exp_s ? c + DBNC : -1), "R4 strobe sample", rise_at, exp_s ? c + DBNC : -1);
    chk(hi_cnt == (exp_s ? STRB : 0), "R5 strobe length", hi_cnt, exp_s ? STRB : 0);
    chk(key_code_o == 6'(exp_code), "R4 key code", key_code_o, exp_code);
    chk(next_at == h + 8, "R3 resume after release", next_at, h + 8);
    chk(mode_code_o == 6'(exp_mcode), (r == MODE_ROW && exp_s && !acc) ? "R7 mode code kept" : "R6 mode code",
        mode_code_o, exp_mcode);
    chk(mode_lock_o == exp_lock, "R6 mode lock", mode_lock_o, exp_lock);
    chk(act_h == acc, "R8 mode active while held", act_h, acc);
    chk(act_r == 1'b0, "R8 mode active after release", act_r, 0);
  endtask

  task automatic do_clear();
    @(negedge clk_i);
    mode_clr_i = 1'b1;
    @(negedge clk_i);
    mode_clr_i = 1'b0;
    exp_lock = 1'b0;
    exp_mcode = 0;
    chk(mode_lock_o == 1'b0, "R9 lock cleared", mode_lock_o, 0);
    chk(mode_code_o == 6'd0, "R9 mode code cleared", mode_code_o, 0);
    chk(mode_active_o == 1'b0, "R9 mode active cleared", mode_active_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    chk(1'b0, "watchdog", 1, 0);
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n_i = 1'b0;
    mode_clr_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(drive_n_o == 8'hFE, "R1 reset drive", drive_n_o, 8'hFE);
    chk(key_valid_o == 1'b0, "R1 reset strobe", key_valid_o, 0);
    chk(key_code_o == 6'd0, "R1 reset code", key_code_o, 0);
    chk(mode_lock_o == 1'b0 && mode_code_o == 6'd0 && mode_active_o == 1'b0,
        "R1 reset mode", mode_lock_o, 0);
    rst_n_i = 1'b1;
    repeat (4) @(negedge clk_i);

    do_press(2, 5, DBNC + 30);   // R2 R4 long hold, single strobe
    do_press(3, 7, DBNC - 1);    // R4 short press, no strobe
    do_press(4, 0, DBNC);        // R4 exact boundary
    do_press(5, 3, 1);           // R3 bounce
    do_press(6, 7, DBNC + 2);    // R3 row carry on resume
    do_press(7, 2, DBNC + 5);    // R6 accepted mode key
    do_press(7, 5, DBNC + 8);    // R7 refused mode key
    do_press(7, 7, DBNC + 1);    // R7 refused, wrap to row 0
    do_clear();                  // R9
    do_press(7, 5, DBNC + 3);    // R9 accepted after clear

    for (int k = 0; k < 24; k++) begin
      int r = int'($urandom % 8);
      int c = int'($urandom % 8);
      int h = 1 + int'($urandom % 40);
      if ($urandom % 6 == 0) do_clear();
      do_press(r, c, h);
    end
    summary();
  end
endmodule